// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block tracks in-flight loads of an out-of-order core in a circular queue. Loads are allocated in program order, each receiving the current tail slot as its load index and recording a 16-bit sequence number. When a load executes, its effective address is written into its slot and the slot is marked as executed. Commit drains old loads from the head against a youngest-committed sequence bound. A squash trims wrong-path loads from the tail against a squash bound.

When a store executes, the core presents the load index the store captured at its own allocation, together with the store address. The block compares, in a single cycle, every executed load from that index up to the current tail against the store's 256-byte block. The oldest matching load in that span is latched as the ordering violator, and the check reports a fault in the same cycle. The violator stays latched until the core consumes it with a read strobe. While a violator is pending, further store checks are skipped.

Top module: `lqg_top`

## Requirements
- R1: After reset the queue is empty: count 0, head 0, tail 0, empty high, full low and no violator pending.
- R2: An allocation presents the current tail on `alloc_idx`, writes the sequence number into that slot, and advances the tail by one, wrapping from DEPTH-1 to 0. An allocation while full is ignored.
- R3: A commit removes entries from the head for as long as the queue is non-empty and the head entry's sequence number is less than or equal to the bound (equality retires). It stops at the first entry above the bound.
- R4: A squash removes entries from tail-1 backwards for as long as the queue is non-empty and the entry's sequence number is greater than the bound. The tail moves back to match and wraps from 0 to DEPTH-1. In a squash cycle, allocation and commit are ignored.
- R5: A store check covers only slots from the given load index up to, but not including, the current tail, taken circularly. If the index equals the tail, the span is empty.
- R6: A load matches a store when the two addresses agree in every bit above the low 8 bits (address >> 8).
- R7: A slot that was allocated but has not yet executed never matches, whatever its stored address.
- R8: On a match, `chk_fault` is high in the same cycle, and from the next cycle the violator outputs hold the index and sequence number of the matching load nearest the check's starting index.
- R9: While a violator is pending, a store check reports no fault and leaves the violator unchanged.
- R10: The violator outputs are valid before a read. Asserting `viol_take` clears the violator at that clock edge.
- R11: `q_full` is high exactly when the count equals DEPTH-1, since one slot always stays unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load slot |
| alloc_seq | input | 16 | Sequence number of the allocated load |
| alloc_idx | output | 4 | Slot the next allocation receives (current tail) |
| q_full | output | 1 | Queue full (DEPTH-1 entries) |
| q_empty | output | 1 | Queue empty |
| q_count | output | 5 | Number of live entries |
| q_head | output | 4 | Oldest live slot |
| q_tail | output | 4 | Next free slot |
| exec_valid | input | 1 | A load has executed |
| exec_idx | input | 4 | Slot of the executed load |
| exec_addr | input | 32 | Effective address of the executed load |
| chk_valid | input | 1 | Store ordering check request |
| chk_ldidx | input | 4 | Load index the store captured at allocation |
| chk_addr | input | 32 | Store effective address |
| chk_fault | output | 1 | Check found a younger executed load in the same block |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 16 | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Sequence number at or below which loads survive |
| viol_take | input | 1 | Read and clear the violator |
| viol_valid | output | 1 | Violator pending |
| viol_idx | output | 4 | Slot of the violating load |
| viol_seq | output | 16 | Sequence number of the violating load |

## Verification
On every cycle, the assertions check that a pending violator suppresses faults and holds its slot, that a fault always latches a violator and that a read clears it. They also check that a full queue rejects an allocation and that commits and squashes never grow the queue. Only the bench scenarios can show which load is selected: the nearest match within a circular span, the exclusion of slots outside the span or not yet executed, and the block-granular address compare. The exact number of entries retired or trimmed against the sequence bounds, including the equal-bound case and pointer wrap in both directions, is likewise shown only by the scenarios.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
  localparam int LQG_DEPTH     = 16;
  localparam int LQG_SEQ_W     = 16;
  localparam int LQG_ADDR_W    = 32;
  localparam int LQG_BLK_SHIFT = 8;

  // circular index arithmetic on plain integers
  function automatic int wrap_add(input int a, input int b, input int depth);
    return (a + b) % depth;
  endfunction

  function automatic int wrap_sub(input int a, input int b, input int depth);
    return (a - b + depth) % depth;
  endfunction
endpackage

// File: rtl/lqg_entries.sv
module lqg_entries #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int IW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic              ex_en,
  input  logic [IW-1:0]     ex_idx,
  input  logic [ADDR_W-1:0] ex_addr,
  output logic [SEQ_W-1:0]  seq_o  [DEPTH],
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [DEPTH-1:0]  done_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_wr, hit_ex;
    assign hit_wr = wr_en && (wr_idx == IW'(g));
    assign hit_ex = ex_en && (ex_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq_o[g]  <= '0;
        addr_o[g] <= '0;
        done_o[g] <= 1'b0;
      end else if (hit_wr) begin
        seq_o[g]  <= wr_seq;
        done_o[g] <= 1'b0;
      end else if (hit_ex) begin
        addr_o[g] <= ex_addr;
        done_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lqg_ring.sv
module lqg_ring import lqg_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int IW    = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             commit_req,
  input  logic [SEQ_W-1:0] commit_bound,
  input  logic             squash_req,
  input  logic [SEQ_W-1:0] squash_bound,
  input  logic [SEQ_W-1:0] seq_i [DEPTH],
  output logic [IW-1:0]    head,
  output logic [IW-1:0]    tail,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             alloc_fire,
  output logic [CW-1:0]    commit_n,
  output logic [CW-1:0]    squash_n
);
  int  cnt_i, head_i, tail_i;
  int  c_n, s_n;
  logic c_go, s_go;

  assign cnt_i  = int'(count);
  assign head_i = int'(head);
  assign tail_i = int'(tail);
  assign full   = (count == CW'(DEPTH - 1));
  assign empty  = (count == '0);
  assign alloc_fire = alloc_req && !full && !squash_req;

  // run of retirable entries from the head
  always_comb begin
    c_go = 1'b1;
    c_n  = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (c_go && k < cnt_i &&
          seq_i[IW'(wrap_add(head_i, k, DEPTH))] <= commit_bound)
        c_n = c_n + 1;
      else
        c_go = 1'b0;
    end
    commit_n = (commit_req && !squash_req) ? CW'(c_n) : '0;
  end

  // run of wrong-path entries backwards from tail-1
  always_comb begin
    s_go = 1'b1;
    s_n  = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (s_go && k < cnt_i &&
          seq_i[IW'(wrap_sub(tail_i, k + 1, DEPTH))] > squash_bound)
        s_n = s_n + 1;
      else
        s_go = 1'b0;
    end
    squash_n = squash_req ? CW'(s_n) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (squash_req) begin
      tail  <= IW'(wrap_sub(tail_i, int'(squash_n), DEPTH));
      count <= count - squash_n;
    end else begin
      head  <= IW'(wrap_add(head_i, int'(commit_n), DEPTH));
      tail  <= IW'(wrap_add(tail_i, alloc_fire ? 1 : 0, DEPTH));
      count <= count - commit_n + CW'(alloc_fire);
    end
  end
endmodule

// File: rtl/lqg_scan.sv
module lqg_scan import lqg_pkg::*; #(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8,
  parameter int IW        = 4
) (
  input  logic [IW-1:0]     start_idx,
  input  logic [IW-1:0]     tail,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [DEPTH-1:0]  done_i,
  output logic              hit,
  output logic [IW-1:0]     hit_idx
);
  localparam int BW = ADDR_W - BLK_SHIFT;

  int span;
  int ix;
  logic [DEPTH-1:0] blk_eq;

  assign span = wrap_sub(int'(tail), int'(start_idx), DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign blk_eq[g] = done_i[g] &&
      (addr_i[g][ADDR_W-1:BLK_SHIFT] == st_addr[ADDR_W-1:BLK_SHIFT]);
  end

  // nearest match to the starting index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    ix      = 0;
    for (int d = 0; d < DEPTH; d++) begin
      ix = wrap_add(int'(start_idx), d, DEPTH);
      if (!hit && d < span && blk_eq[IW'(ix)]) begin
        hit     = 1'b1;
        hit_idx = IW'(ix);
      end
    end
  end

  initial begin
    if (BW < 1) $error("block shift leaves no block bits");
  end
endmodule

// File: rtl/lqg_top.sv
module lqg_top import lqg_pkg::*; #(
  parameter int DEPTH     = LQG_DEPTH,
  parameter int SEQ_W     = LQG_SEQ_W,
  parameter int ADDR_W    = LQG_ADDR_W,
  parameter int BLK_SHIFT = LQG_BLK_SHIFT,
  parameter int IW        = $clog2(DEPTH),
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  output logic              q_full,
  output logic              q_empty,
  output logic [CW-1:0]     q_count,
  output logic [IW-1:0]     q_head,
  output logic [IW-1:0]     q_tail,
  input  logic              exec_valid,
  input  logic [IW-1:0]     exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              chk_valid,
  input  logic [IW-1:0]     chk_ldidx,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_fault,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              viol_take,
  output logic              viol_valid,
  output logic [IW-1:0]     viol_idx,
  output logic [SEQ_W-1:0]  viol_seq
);
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DEPTH-1:0]  ent_done;
  logic              alloc_fire;
  logic [CW-1:0]     commit_n, squash_n;
  logic              scan_hit;
  logic [IW-1:0]     scan_idx;
  logic              chk_go;

  lqg_entries #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .IW(IW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(q_tail), .wr_seq(alloc_seq),
    .ex_en(exec_valid), .ex_idx(exec_idx), .ex_addr(exec_addr),
    .seq_o(ent_seq), .addr_o(ent_addr), .done_o(ent_done)
  );

  lqg_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IW(IW), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_valid),
    .commit_req(commit_valid), .commit_bound(commit_seq),
    .squash_req(squash_valid), .squash_bound(squash_seq),
    .seq_i(ent_seq),
    .head(q_head), .tail(q_tail), .count(q_count),
    .full(q_full), .empty(q_empty),
    .alloc_fire(alloc_fire), .commit_n(commit_n), .squash_n(squash_n)
  );

  lqg_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .IW(IW)) u_scan (
    .start_idx(chk_ldidx), .tail(q_tail), .st_addr(chk_addr),
    .addr_i(ent_addr), .done_i(ent_done),
    .hit(scan_hit), .hit_idx(scan_idx)
  );

  assign alloc_idx = q_tail;
  assign chk_go    = chk_valid && !viol_valid;
  assign chk_fault = chk_go && scan_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_idx   <= '0;
      viol_seq   <= '0;
    end else if (chk_fault) begin
      viol_valid <= 1'b1;
      viol_idx   <= scan_idx;
      viol_seq   <= ent_seq[scan_idx];
    end else if (viol_take) begin
      viol_valid <= 1'b0;
    end
  end

  // R9: a pending violator suppresses any fault
  a_r9_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> !chk_fault);

  // R9: a pending, unread violator keeps its slot
  a_r9_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_take) |=> (viol_valid && $stable(viol_idx)));

  // R8: a fault leaves a violator latched
  a_r8_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |=> viol_valid);

  // R10: reading clears the violator
  a_r10_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_take && viol_valid) |=> !viol_valid);

  // R2: a full queue rejects an allocation
  a_r2_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && q_full && !squash_valid && !commit_valid) |=> $stable(q_tail));

  // R4: a squash never grows the queue
  a_r4_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (q_count <= $past(q_count) && $stable(q_head)));

  // R3: a commit alone never grows the queue or moves the tail
  a_r3_commit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !squash_valid && !alloc_valid) |=>
      (q_count <= $past(q_count) && $stable(q_tail)));
endmodule

// File: tb/lqg_top_tb.sv
module lqg_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_seq = '0;
  logic [3:0]  alloc_idx;
  logic        q_full, q_empty;
  logic [4:0]  q_count;
  logic [3:0]  q_head, q_tail;
  logic        exec_valid = 1'b0;
  logic [3:0]  exec_idx = '0;
  logic [31:0] exec_addr = '0;
  logic        chk_valid = 1'b0;
  logic [3:0]  chk_ldidx = '0;
  logic [31:0] chk_addr = '0;
  logic        chk_fault;
  logic        commit_valid = 1'b0;
  logic [15:0] commit_seq = '0;
  logic        squash_valid = 1'b0;
  logic [15:0] squash_seq = '0;
  logic        viol_take = 1'b0;
  logic        viol_valid;
  logic [3:0]  viol_idx;
  logic [15:0] viol_seq;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  lqg_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
    .q_full(q_full), .q_empty(q_empty), .q_count(q_count),
    .q_head(q_head), .q_tail(q_tail),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .chk_valid(chk_valid), .chk_ldidx(chk_ldidx), .chk_addr(chk_addr),
    .chk_fault(chk_fault),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .viol_take(viol_take), .viol_valid(viol_valid),
    .viol_idx(viol_idx), .viol_seq(viol_seq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change 2 time units after a rising edge; the edge commits them
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    alloc_valid = 0; exec_valid = 0; chk_valid = 0;
    commit_valid = 0; squash_valid = 0; viol_take = 0;
  endtask

  task automatic do_alloc(input int seq, input int exp_idx);
    alloc_valid = 1; alloc_seq = 16'(seq);
    #1 check("R2 alloc index", int'(alloc_idx), exp_idx);
    tick(); idle();
  endtask

  task automatic do_exec(input int idx, input int addr);
    exec_valid = 1; exec_idx = 4'(idx); exec_addr = 32'(addr);
    tick(); idle();
  endtask

  // store check: compare the same-cycle fault, then the violator afterwards
  task automatic do_chk(input string req, input int start, input int addr,
                        input int exp_fault, input int exp_vidx, input int exp_vseq);
    chk_valid = 1; chk_ldidx = 4'(start); chk_addr = 32'(addr);
    #1 check({req, " fault"}, int'(chk_fault), exp_fault);
    tick(); idle();
    if (exp_vidx >= 0) begin
      check({req, " violator valid"}, int'(viol_valid), 1);
      check({req, " violator idx"}, int'(viol_idx), exp_vidx);
      check({req, " violator seq"}, int'(viol_seq), exp_vseq);
    end else begin
      check({req, " no violator"}, int'(viol_valid), 0);
    end
  endtask

  task automatic do_take();
    viol_take = 1;
    tick(); idle();
    check("R10 cleared after read", int'(viol_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 count", int'(q_count), 0);
    check("R1 head", int'(q_head), 0);
    check("R1 tail", int'(q_tail), 0);
    check("R1 empty", int'(q_empty), 1);
    check("R1 full", int'(q_full), 0);
    check("R1 violator", int'(viol_valid), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 5; i++) do_alloc(10 * (i + 1), i);
    check("R2 count after five", int'(q_count), 5);
    check("R2 tail after five", int'(q_tail), 5);
    do_exec(0, 'h0100);
    do_exec(1, 'h1234);
    do_exec(2, 'h4000);
    do_exec(3, 'h12FF);
  endtask

  task automatic t_detect();
    // R8 R6: slots 1 and 3 share block 0x12; nearest to start 0 is slot 1
    do_chk("R8 first match", 0, 'h12AB, 1, 1, 20);
    // R9: slot 2 would match, but a violator is pending
    do_chk("R9 suppressed", 0, 'h4000, 0, 1, 20);
    check("R10 value before read", int'(viol_idx), 1);
    do_take();
  endtask

  task automatic t_range();
    // R5: start 2 excludes slot 1
    do_chk("R5 range start", 2, 'h1200, 1, 3, 40);
    do_take();
    // R7: slot 4 unexecuted, stored address still zero
    do_chk("R7 unexecuted", 4, 'h0000, 0, -1, 0);
    // R6: 0x12FF and 0x1300 are in different blocks
    do_chk("R6 block differs", 3, 'h1300, 0, -1, 0);
  endtask

  task automatic t_commit();
    commit_valid = 1; commit_seq = 16'd5;
    tick(); idle();
    check("R3 bound below head", int'(q_count), 5);
    commit_valid = 1; commit_seq = 16'd20;
    tick(); idle();
    check("R3 equal bound count", int'(q_count), 3);
    check("R3 head", int'(q_head), 2);
  endtask

  task automatic t_squash();
    squash_valid = 1; squash_seq = 16'd35;
    alloc_valid = 1; alloc_seq = 16'd99;
    commit_valid = 1; commit_seq = 16'd60;
    tick(); idle();
    check("R4 squash count", int'(q_count), 1);
    check("R4 squash tail", int'(q_tail), 3);
    check("R4 head untouched", int'(q_head), 2);
  endtask

  task automatic t_wrap_full();
    for (int i = 0; i < 14; i++) do_alloc(100 + i, (3 + i) % 16);
    check("R11 full at depth-1", int'(q_full), 1);
    check("R2 wrapped tail", int'(q_tail), 1);
    alloc_valid = 1; alloc_seq = 16'd200;
    tick(); idle();
    check("R2 full ignores alloc tail", int'(q_tail), 1);
    check("R2 full ignores alloc count", int'(q_count), 15);
  endtask

  task automatic t_wrap_check();
    do_exec(0, 'h5500);
    do_exec(2, 'h5500);
    // R5: span 15..0 wraps; slot 0 (seq 113) is the match
    do_chk("R5 wrapped span", 15, 'h55AA, 1, 0, 113);
    do_take();
    // R5: start equal to tail is an empty span, slot 2 is never looked at
    do_chk("R5 empty span", 1, 'h5500, 0, -1, 0);
  endtask

  task automatic t_squash_wrap();
    squash_valid = 1; squash_seq = 16'd111;
    tick(); idle();
    check("R4 tail wraps back", int'(q_tail), 15);
    check("R4 count after wrap", int'(q_count), 13);
    check("R11 not full", int'(q_full), 0);
    commit_valid = 1; commit_seq = 16'hFFFF;
    tick(); idle();
    check("R3 drain count", int'(q_count), 0);
    check("R3 drain head", int'(q_head), 15);
    check("R3 drain empty", int'(q_empty), 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_detect();
    t_range();
    t_commit();
    t_squash();
    t_wrap_full();
    t_wrap_check();
    t_squash_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule